// File: doc/BRIEF.md
# Weighted-Binary Stochastic Bit-Stream Generator

This block turns an N-bit unsigned value `x` into a serial stream of random-looking bits, one per clock. The share of ones in the stream approximates `x / 2^N`. A free-running maximal-length shift register supplies a pseudo-random state every cycle. A shared leading-one detector turns that state into a one-hot weight vector. The weight vector is masked with `x`, and the result is OR-reduced into a registered output bit.

The leading-one detector inverts the state and passes it through one AND chain that runs from the top bit downward. Once the chain meets a set state bit, every lower node is zero. Each weight below the top one is the XOR of two neighbouring chain nodes. The top weight is the top state bit itself. One such structure therefore covers all N weights, with no separate pattern matcher per weight.

An input `zero_en` adds the all-zero state to the sequence, which makes the period exactly 2^N. Under that mode the number of ones in any 2^N consecutive outputs equals `x` exactly. Without the mode the period is 2^N − 1.

Top module: `sng_wb_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the state becomes 0…01 and `bit_o` becomes 0.
- R2: With `en` high, `ld` low and `zero_en` low, the state shifts right by one place. The new MSB is the XOR of the state bits selected by the tap mask. For N=8 the mask is 8'h1D, which selects bits 0, 2, 3 and 4, and the period is 255.
- R3: With `zero_en` high, the state 0…01 is followed by the all-zero state. The all-zero state is followed by 10…0. The period is 2^N.
- R4: The weight vector has at most one bit set. When it is not zero, its set bit is at the position of the highest set bit of the state. It is all zero only for the all-zero state.
- R5: With `en` high, the value of `bit_o` after an edge is the OR over k of weight[k] AND x[k]. The weights used are those of the state held before that edge.
- R6: With `zero_en` and `en` held high, the ones on `bit_o` over any 2^N consecutive cycles number exactly `x`, for every value of `x`.
- R7: `ld` high with a nonzero `seed` places `seed` in the state at the next edge. This holds whatever the level of `en`.
- R8: `ld` high with a zero `seed` has no effect when `zero_en` is low. When `zero_en` is high, the zero seed is loaded.
- R9: With `en` low and no load, the state and `bit_o` both hold their values.
- R10: `x` = 0 gives a constant 0 on `bit_o`. `x` = all ones gives 0 only for the all-zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the state and update the output |
| zero_en | input | 1 | Add the all-zero state to the sequence |
| ld | input | 1 | Load `seed` into the state |
| seed | input | N | Seed value |
| x | input | N | Unsigned binary value to convert |
| bit_o | output | 1 | Registered stochastic output bit |

## Verification
The state can only be seen through `bit_o`. Probing with `x` values that have a single bit set shows which weight fires in each cycle. A wrong feedback tap or a wrong zero insertion therefore shows up as a stream mismatch within a few cycles of the state concerned. Over a full period it also changes the count of ones, so the exact-count sweep over all 256 inputs exposes it. A weight that fires on the wrong position, or two weights that fire together, move the ones count away from `x` within one 2^N window.

// File: rtl/sng_pkg.sv
package sng_pkg;
  // Feedback mask for a right-shifting register whose new MSB is XOR(state & mask)
  function automatic logic [31:0] tap_mask(input int n);
    case (n)
      3:  return 32'h0000_0003;
      4:  return 32'h0000_0003;
      5:  return 32'h0000_0005;
      6:  return 32'h0000_0003;
      7:  return 32'h0000_0003;
      8:  return 32'h0000_001D;
      10: return 32'h0000_0009;
      12: return 32'h0000_0941;
      16: return 32'h0000_100B;
      default: return 32'h0000_0003;
    endcase
  endfunction
endpackage

// File: rtl/sng_lfsr.sv
module sng_lfsr #(
  parameter int N = 8,
  parameter logic [N-1:0] TAPS = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         zero_en,
  input  logic         ld,
  input  logic [N-1:0] seed,
  output logic [N-1:0] state
);
  localparam logic [N-1:0] RST_VAL = {{(N-1){1'b0}}, 1'b1};

  logic fb;
  logic low_clear;
  logic seed_ok;

  assign low_clear = (state[N-1:1] == '0);
  assign fb        = (^(state & TAPS)) ^ (zero_en & low_clear);
  assign seed_ok   = ld && ((seed != '0) || zero_en);

  always_ff @(posedge clk) begin
    if (rst)          state <= RST_VAL;
    else if (seed_ok) state <= seed;
    else if (en)      state <= {fb, state[N-1:1]};
  end
endmodule

// File: rtl/sng_weight.sv
module sng_weight #(
  parameter int N = 8
) (
  input  logic [N-1:0] state,
  output logic [N-1:0] weight
);
  logic [N-1:0] chain;

  assign chain[N-1]  = ~state[N-1];
  assign weight[N-1] = state[N-1];

  generate
    for (genvar k = N - 2; k >= 0; k--) begin : g_chain
      assign chain[k]  = chain[k+1] & ~state[k];
      assign weight[k] = chain[k+1] ^ chain[k];
    end
  endgenerate
endmodule

// File: rtl/sng_select.sv
module sng_select #(
  parameter int N = 8
) (
  input  logic [N-1:0] weight,
  input  logic [N-1:0] x,
  output logic         bit_n
);
  assign bit_n = |(weight & x);
endmodule

// File: rtl/sng_wb_gen.sv
module sng_wb_gen
  import sng_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         zero_en,
  input  logic         ld,
  input  logic [N-1:0] seed,
  input  logic [N-1:0] x,
  output logic         bit_o
);
  localparam logic [31:0]  TAPS_ALL = tap_mask(N);
  localparam logic [N-1:0] TAPS     = TAPS_ALL[N-1:0];

  logic [N-1:0] lfsr_q;
  logic [N-1:0] wgt;
  logic         bit_n;

  sng_lfsr #(.N(N), .TAPS(TAPS)) u_lfsr (
    .clk(clk), .rst(rst), .en(en), .zero_en(zero_en),
    .ld(ld), .seed(seed), .state(lfsr_q)
  );

  sng_weight #(.N(N)) u_weight (.state(lfsr_q), .weight(wgt));

  sng_select #(.N(N)) u_select (.weight(wgt), .x(x), .bit_n(bit_n));

  always_ff @(posedge clk) begin
    if (rst)     bit_o <= 1'b0;
    else if (en) bit_o <= bit_n;
  end
endmodule

// File: rtl/sng_wb_chk.sv
module sng_wb_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic         zero_en,
  input logic         ld,
  input logic [N-1:0] seed,
  input logic [N-1:0] state,
  input logic [N-1:0] weight,
  input logic         bit_o
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};
  localparam logic [N-1:0] TOP = {1'b1, {(N-1){1'b0}}};

  // R4: at most one weight active
  a_r4_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(weight));
  // R4: zero state yields no weight
  a_r4_zero: assert property (@(posedge clk) disable iff (rst) (state == '0) |-> (weight == '0));
  // R4: a nonzero state selects one of its own set bits
  a_r4_hit: assert property (@(posedge clk) disable iff (rst) (state != '0) |-> ((weight & state) != '0));
  // R7: nonzero seed is loaded
  a_r7_load: assert property (@(posedge clk) disable iff (rst) (ld && seed != '0) |=> (state == $past(seed)));
  // R8: zero seed ignored without zero mode
  a_r8_zero_seed: assert property (@(posedge clk) disable iff (rst) (ld && seed == '0 && !zero_en && !en) |=> $stable(state));
  // R9: disabled generator holds
  a_r9_freeze: assert property (@(posedge clk) disable iff (rst) (!en && !ld) |=> ($stable(state) && $stable(bit_o)));
  // R3: zero state entry and exit
  a_r3_enter: assert property (@(posedge clk) disable iff (rst) (en && !ld && zero_en && state == ONE) |=> (state == '0));
  a_r3_leave: assert property (@(posedge clk) disable iff (rst) (en && !ld && zero_en && state == '0) |=> (state == TOP));
endmodule

bind sng_wb_gen sng_wb_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .en(en), .zero_en(zero_en), .ld(ld),
  .seed(seed), .state(lfsr_q), .weight(wgt), .bit_o(bit_o)
);

// File: tb/test_sng_wb_gen.sv
`timescale 1ns/1ps
module test_sng_wb_gen;
  localparam int N = 8;
  localparam logic [N-1:0] MASK = 8'h1D;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic zero_en = 1'b0;
  logic ld = 1'b0;
  logic [N-1:0] seed = '0;
  logic [N-1:0] x = '0;
  logic bit_o;

  always #2 clk = ~clk;

  sng_wb_gen #(.N(N)) i_sng_wb_gen (
    .clk(clk), .rst(rst), .en(en), .zero_en(zero_en), .ld(ld),
    .seed(seed), .x(x), .bit_o(bit_o)
  );

  typedef struct { logic exp; string tag; } sb_item_t;
  sb_item_t sbq[$];
  sb_item_t cur;

  int checks = 0;
  int errs = 0;
  logic [N-1:0] m_state = 8'h01;
  logic         m_out = 1'b0;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Spec model: leading one position drives the selected x bit
  function automatic logic model_bit(input logic [N-1:0] s, input logic [N-1:0] xv);
    for (int k = N - 1; k >= 0; k--)
      if (s[k]) return xv[k];
    return 1'b0;
  endfunction

  function automatic logic [N-1:0] model_next(input logic [N-1:0] s, input logic z);
    logic f;
    f = ^(s & MASK);
    if (z && s[N-1:1] == '0) f = ~f;
    return {f, s[N-1:1]};
  endfunction

  task automatic step(input logic e, input logic l, input logic [N-1:0] sd,
                      input logic [N-1:0] xv, input logic z, input string tag);
    logic [N-1:0] ns;
    logic no;
    sb_item_t it;
    @(negedge clk);
    en = e; ld = l; seed = sd; x = xv; zero_en = z;
    no = e ? model_bit(m_state, xv) : m_out;
    if (l && (sd != '0 || z)) ns = sd;
    else if (e)               ns = model_next(m_state, z);
    else                      ns = m_state;
    @(posedge clk);
    #1;
    m_state = ns;
    m_out = no;
    it.exp = no;
    it.tag = tag;
    sbq.push_back(it);
  endtask

  always @(negedge clk) begin
    if (sbq.size() != 0) begin
      cur = sbq.pop_front();
      check(bit_o === cur.exp, cur.tag, int'(bit_o), int'(cur.exp));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(bit_o === 1'b0, "R1 reset output", int'(bit_o), 0);
    rst = 1'b0;
    // R1 via stream: state 0..01 seen by x=01
    step(1, 0, 0, 8'h01, 0, "R1");
    // R2: free run with a varied mask pattern
    for (int i = 0; i < 300; i++) step(1, 0, 0, 8'h5A, 0, "R2");
    for (int i = 0; i < 40; i++) step(1, 0, 0, 8'h80, 0, "R5");
    // R7: load while disabled and while enabled
    step(0, 1, 8'h01, 8'h01, 0, "R7");
    step(1, 1, 8'h24, 8'h20, 0, "R7");
    // R3: zero state inserted after 0..01, seen with x all ones
    step(1, 1, 8'h02, 8'hFF, 1, "R7");
    for (int i = 0; i < 20; i++) step(1, 0, 0, 8'hFF, 1, "R3");
    for (int i = 0; i < 20; i++) step(1, 0, 0, 8'h01, 1, "R3");
    // R8: zero seed ignored without zero mode, taken with it
    step(1, 1, 8'h00, 8'h0F, 0, "R8");
    for (int i = 0; i < 10; i++) step(1, 0, 0, 8'h0F, 0, "R8");
    step(1, 1, 8'h00, 8'hFF, 1, "R8");
    step(1, 0, 0, 8'hFF, 1, "R8");
    step(1, 0, 0, 8'hFF, 1, "R8");
    // R9: hold with inputs changing
    for (int i = 0; i < 8; i++) step(0, 0, 0, 8'hFF ^ 8'(i), 0, "R9");
    step(1, 0, 0, 8'h33, 0, "R9");
    // R10: x zero and all ones
    for (int i = 0; i < 100; i++) step(1, 0, 0, 8'h00, 0, "R10");
    for (int i = 0; i < 30; i++) step(1, 0, 0, 8'hFF, 0, "R10");
    // R6: exact count over 2^N cycles for every x
    for (int v = 0; v < 256; v++) begin
      cnt = 0;
      for (int c = 0; c < 256; c++) begin
        step(1, 0, 0, 8'(v), 1, "R5");
        cnt += int'(bit_o);
      end
      check(cnt == v, "R6 ones count", cnt, v);
    end
    @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule